// File: doc/BRIEF.md
# Scalar Compare and Short-Immediate Execution Unit

This unit executes the scalar-pipeline instructions that either produce a condition flag or work with a 16-bit signed immediate. It covers register-register compares and register-immediate compares, each with six conditions in signed and unsigned form. It also runs single-bit tests on a 32-bit or a 64-bit source, and four immediate operations: load immediate, conditional load immediate, add immediate and multiply immediate. The immediate is always sign-extended to 32 bits before use. For the immediate forms, the value of the destination register arrives on the first operand.

Each operation is presented as one transfer on a valid/ready input. A transfer is accepted on a rising edge while `in_valid` and `in_ready` are both high. One cycle later it appears on a registered valid/ready output, together with the data result, the data write-enable, the next condition flag and the flag write-enable. The input is ready whenever the output register is empty or is being drained in the same cycle. While the output is held (`out_valid` high, `out_ready` low), the input stalls and every output bit stays frozen. Opcodes outside the defined map raise `out_illegal` and suppress both write-enables.

Opcode map (6 bits): bit 5 set means illegal. Bits 4:3 select a group: 00 signed register compare, 01 unsigned register compare, 10 signed immediate compare, 11 unsigned immediate compare. Bits 2:0 values 0 to 5 select the condition: 0 equal, 1 not-equal, 2 greater, 3 greater-or-equal, 4 less, 5 less-or-equal. The codes with bits 2:0 equal to 6 or 7 in each group are the other operations:

| Code | Operation |
|------|-----------|
| 6 | load immediate |
| 7 | conditional load immediate |
| 14 | add immediate |
| 15 | multiply immediate |
| 22 | test 32-bit bit for 0 |
| 23 | test 32-bit bit for 1 |
| 30 | test 64-bit bit for 0 |
| 31 | test 64-bit bit for 1 |

Top module: `scalar_cmpimm_unit`

## Requirements
- R1: Opcodes 0 to 5 compare `in_opa` against `in_opb` as signed two's-complement values (conditions equal, not-equal, greater, greater-or-equal, less, less-or-equal), and `out_scc` carries the outcome.
- R2: Opcodes 8 to 13 perform the same six compares with both operands treated as unsigned.
- R3: Every compare and every bit test drives `out_scc_we` high and `out_res_we` low, with `out_result` zero.
- R4: Opcodes 16 to 21 (signed) and 24 to 29 (unsigned) compare `in_opa` on the left against the sign-extended `in_imm` on the right. In the unsigned form, immediate 0xFFFF therefore means 0xFFFFFFFF.
- R5: Opcode 6 writes the sign-extended `in_imm` with `out_res_we` high and `out_scc_we` low.
- R6: Opcode 7 writes the sign-extended `in_imm` when `in_scc` is 1. When `in_scc` is 0 it drives `out_res_we` low and returns `in_opa` unchanged on `out_result`.
- R7: Opcode 14 writes the low 32 bits of `in_opa` plus the sign-extended immediate. Opcode 15 writes the low 32 bits of their product. Both drive `out_res_we` high.
- R8: Opcodes 22 and 23 test bit (`in_opb` AND 0x1F) of `in_opa`. `out_scc` is 1 when that bit equals opcode bit 0.
- R9: Opcodes 30 and 31 test bit (`in_opb` AND 0x3F) of the 64-bit value {`in_opa_hi`, `in_opa`}. `out_scc` is 1 when that bit equals opcode bit 0.
- R10: Any opcode with bit 5 set drives `out_illegal` high and both write-enables low.
- R11: Results are registered. An operation accepted on one rising edge is presented with `out_valid` high after that edge. Operations that do not write the flag return `in_scc` on `out_scc` with `out_scc_we` low.
- R12: `in_ready` is high exactly when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, all outputs hold their values.
- R13: During and right after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Unit can accept an operation |
| in_op | input | 6 | Opcode |
| in_opa | input | 32 | First source, or destination value for immediate forms |
| in_opa_hi | input | 32 | Upper half of the 64-bit bit-test source |
| in_opb | input | 32 | Second source, or bit index |
| in_imm | input | 16 | Signed immediate |
| in_scc | input | 1 | Current condition flag |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Data result |
| out_res_we | output | 1 | Data register write-enable |
| out_scc | output | 1 | Next condition flag |
| out_scc_we | output | 1 | Flag write-enable |
| out_illegal | output | 1 | Opcode not defined |

## Verification
Every result of this unit is due exactly one clock after its acceptance edge: flag, data, both enables and the illegal marker all come from the same register. The bench drives each operation on a falling edge, lets one rising edge accept it, and compares all output fields on the next falling edge, half a period clear of any edge. In the stall scenario it samples on each falling edge while the consumer holds back, checks that the held outputs have not moved and the input is not ready, and expects the queued operation one clock after `out_ready` returns.

// File: rtl/scu_pkg.sv
package scu_pkg;

  localparam int OP_W = 6;

  typedef enum logic [2:0] {
    KIND_CMP,
    KIND_MOVI,
    KIND_CMOVI,
    KIND_ADDI,
    KIND_MULI,
    KIND_BT32,
    KIND_BT64,
    KIND_BAD
  } kind_e;

  typedef struct packed {
    kind_e      kind;
    logic       sgn;      // signed compare
    logic       use_imm;  // right operand is the immediate
    logic [2:0] cond;     // 0 eq,1 ne,2 gt,3 ge,4 lt,5 le
    logic       bit_val;  // wanted bit value for bit tests
  } dec_t;

  function automatic dec_t decode_op(input logic [OP_W-1:0] op);
    dec_t d;
    d.kind    = KIND_CMP;
    d.sgn     = ~op[3];
    d.use_imm = op[4];
    d.cond    = op[2:0];
    d.bit_val = op[0];
    if (op[5]) begin
      d.kind = KIND_BAD;
    end else if (op[2:1] == 2'b11) begin
      unique case (op[4:3])
        2'b00: d.kind = op[0] ? KIND_CMOVI : KIND_MOVI;
        2'b01: d.kind = op[0] ? KIND_MULI  : KIND_ADDI;
        2'b10: d.kind = KIND_BT32;
        default: d.kind = KIND_BT64;
      endcase
    end
    return d;
  endfunction

endpackage

// File: rtl/scu_compare.sv
module scu_compare #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         is_signed,
  input  logic [2:0]   cond,
  output logic         hit
);
  logic eq, lt;

  always_comb begin
    eq = (lhs == rhs);
    if (is_signed) lt = ($signed(lhs) < $signed(rhs));
    else           lt = (lhs < rhs);
    unique case (cond)
      3'd0:    hit = eq;
      3'd1:    hit = ~eq;
      3'd2:    hit = ~lt & ~eq;
      3'd3:    hit = ~lt;
      3'd4:    hit = lt;
      3'd5:    hit = lt | eq;
      default: hit = 1'b0;
    endcase
  end
endmodule

// File: rtl/scu_bittest.sv
module scu_bittest #(
  parameter int SRC_W = 32,
  localparam int IDX_W = $clog2(SRC_W)
) (
  input  logic [SRC_W-1:0] src,
  input  logic [IDX_W-1:0] idx,
  input  logic             want,
  output logic             hit
);
  always_comb hit = (src[idx] == want);
endmodule

// File: rtl/scu_immop.sv
module scu_immop #(
  parameter int W = 32
) (
  input  scu_pkg::kind_e kind,
  input  logic [W-1:0]   dst_val,
  input  logic [W-1:0]   imm_x,
  input  logic           scc,
  output logic [W-1:0]   res,
  output logic           res_we
);
  import scu_pkg::*;
  logic [W-1:0] sum, prod;

  always_comb begin
    sum  = dst_val + imm_x;
    prod = dst_val * imm_x;
    res    = '0;
    res_we = 1'b0;
    unique case (kind)
      KIND_MOVI:  begin res = imm_x; res_we = 1'b1; end
      KIND_CMOVI: begin res = scc ? imm_x : dst_val; res_we = scc; end
      KIND_ADDI:  begin res = sum;  res_we = 1'b1; end
      KIND_MULI:  begin res = prod; res_we = 1'b1; end
      default:    begin res = '0;   res_we = 1'b0; end
    endcase
  end
endmodule

// File: rtl/scalar_cmpimm_unit.sv
module scalar_cmpimm_unit #(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [scu_pkg::OP_W-1:0] in_op,
  input  logic [DATA_W-1:0]        in_opa,
  input  logic [DATA_W-1:0]        in_opa_hi,
  input  logic [DATA_W-1:0]        in_opb,
  input  logic [IMM_W-1:0]         in_imm,
  input  logic                     in_scc,
  output logic                     out_valid,
  input  logic                     out_ready,
  output logic [DATA_W-1:0]        out_result,
  output logic                     out_res_we,
  output logic                     out_scc,
  output logic                     out_scc_we,
  output logic                     out_illegal
);
  import scu_pkg::*;

  localparam int EXT_W = DATA_W - IMM_W;

  dec_t              dec;
  logic [DATA_W-1:0] imm_x, cmp_rhs, imm_res;
  logic              imm_we, cmp_hit;
  logic [1:0]        bt_hit;
  logic              accept;

  logic [DATA_W-1:0] nx_result;
  logic              nx_res_we, nx_scc, nx_scc_we, nx_illegal;

  assign dec     = decode_op(in_op);
  assign imm_x   = {{EXT_W{in_imm[IMM_W-1]}}, in_imm};
  assign cmp_rhs = dec.use_imm ? imm_x : in_opb;

  scu_compare #(.W(DATA_W)) u_cmp (
    .lhs(in_opa), .rhs(cmp_rhs), .is_signed(dec.sgn),
    .cond(dec.cond), .hit(cmp_hit)
  );

  for (genvar g = 0; g < 2; g++) begin : g_bt
    localparam int SW = DATA_W << g;
    localparam int IW = $clog2(SW);
    logic [SW-1:0] src;
    if (g == 0) begin : g_narrow
      assign src = in_opa;
    end else begin : g_wide
      assign src = {in_opa_hi, in_opa};
    end
    scu_bittest #(.SRC_W(SW)) u_bt (
      .src(src), .idx(in_opb[IW-1:0]), .want(dec.bit_val), .hit(bt_hit[g])
    );
  end

  scu_immop #(.W(DATA_W)) u_imm (
    .kind(dec.kind), .dst_val(in_opa), .imm_x(imm_x), .scc(in_scc),
    .res(imm_res), .res_we(imm_we)
  );

  always_comb begin
    nx_result  = imm_res;
    nx_res_we  = imm_we;
    nx_scc     = in_scc;
    nx_scc_we  = 1'b0;
    nx_illegal = 1'b0;
    unique case (dec.kind)
      KIND_CMP:  begin nx_scc = cmp_hit;   nx_scc_we = 1'b1; end
      KIND_BT32: begin nx_scc = bt_hit[0]; nx_scc_we = 1'b1; end
      KIND_BT64: begin nx_scc = bt_hit[1]; nx_scc_we = 1'b1; end
      KIND_BAD:  begin nx_illegal = 1'b1; nx_result = '0; nx_res_we = 1'b0; end
      default:   ;
    endcase
  end

  assign in_ready = ~out_valid | out_ready;
  assign accept   = in_valid & in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_res_we  <= 1'b0;
      out_scc     <= 1'b0;
      out_scc_we  <= 1'b0;
      out_illegal <= 1'b0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_result  <= nx_result;
      out_res_we  <= nx_res_we;
      out_scc     <= nx_scc;
      out_scc_we  <= nx_scc_we;
      out_illegal <= nx_illegal;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end

  // R3: flag-writing results never write data
  p_flag_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_scc_we |-> !out_res_we && out_result == '0);

  // R10: illegal results write nothing
  p_illegal_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_illegal |-> !out_res_we && !out_scc_we);

  // R11: accepted work is presented after one edge
  p_latency_r11: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R12: stalled outputs are frozen
  p_stall_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) &&
      $stable(out_scc) && $stable(out_res_we) && $stable(out_scc_we) &&
      $stable(out_illegal));

  // R5: load immediate sign-extends
  p_movi_sext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 6'd6 |=>
      out_res_we && out_result == {{EXT_W{$past(in_imm[IMM_W-1])}}, $past(in_imm)});

  // R6: conditional load with flag clear keeps the destination
  p_cmov_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_op == 6'd7 && !in_scc |=>
      !out_res_we && out_result == $past(in_opa));
endmodule

// File: tb/scalar_cmpimm_unit_tb.sv
module scalar_cmpimm_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_op = '0;
  logic [31:0] in_opa = '0, in_opa_hi = '0, in_opb = '0;
  logic [15:0] in_imm = '0;
  logic        in_scc = 1'b0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_res_we, out_scc, out_scc_we, out_illegal;

  int nvec = 0, nerr = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  scalar_cmpimm_unit u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_opa(in_opa), .in_opa_hi(in_opa_hi), .in_opb(in_opb),
    .in_imm(in_imm), .in_scc(in_scc), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_res_we(out_res_we),
    .out_scc(out_scc), .out_scc_we(out_scc_we), .out_illegal(out_illegal)
  );

  // packed expectation: {valid, illegal, scc_we, scc, res_we, result}
  function automatic logic [36:0] model(input logic [5:0] op, input logic [31:0] a,
      input logic [31:0] ahi, input logic [31:0] b, input logic [15:0] imm, input logic scc);
    logic [31:0] sx, rhs, r;
    logic [63:0] wide;
    logic rwe, s, swe, ill, lt, eq;
    sx = {{16{imm[15]}}, imm};
    r = '0; rwe = 0; s = scc; swe = 0; ill = 0;
    wide = {ahi, a};
    if (op >= 6'd32) ill = 1;
    else if (op == 6'd6)  begin r = sx; rwe = 1; end
    else if (op == 6'd7)  begin r = scc ? sx : a; rwe = scc; end
    else if (op == 6'd14) begin r = a + sx; rwe = 1; end
    else if (op == 6'd15) begin r = a * sx; rwe = 1; end
    else if (op == 6'd22 || op == 6'd23) begin swe = 1; s = (a[b[4:0]] == op[0]); end
    else if (op == 6'd30 || op == 6'd31) begin swe = 1; s = (wide[b[5:0]] == op[0]); end
    else begin
      rhs = (op >= 6'd16) ? sx : b;
      eq  = (a == rhs);
      if (op[3] == 1'b0) lt = $signed(a) < $signed(rhs);
      else               lt = a < rhs;
      swe = 1;
      case (op % 8)
        0: s = eq;
        1: s = !eq;
        2: s = !(lt || eq);
        3: s = !lt;
        4: s = lt;
        default: s = lt || eq;
      endcase
    end
    return {1'b1, ill, swe, s, rwe, r};
  endfunction

  function automatic logic [36:0] observed();
    return {out_valid, out_illegal, out_scc_we, out_scc, out_res_we, out_result};
  endfunction

  task automatic compare(input string req, input logic [36:0] exp);
    nvec++;
    if (observed() !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, observed(), exp);
    end
  endtask

  // starts and ends on a falling edge
  task automatic run(input string req, input logic [5:0] op, input logic [31:0] a,
      input logic [31:0] ahi, input logic [31:0] b, input logic [15:0] imm, input logic scc);
    in_op = op; in_opa = a; in_opa_hi = ahi; in_opb = b; in_imm = imm; in_scc = scc;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    compare(req, model(op, a, ahi, b, imm, scc));
  endtask

  task automatic t_reset();
    nvec++;
    if (out_valid !== 1'b0 || in_ready !== 1'b1) begin
      nerr++;
      $display("FAIL R13: got valid=%b ready=%b expected valid=0 ready=1", out_valid, in_ready);
    end
  endtask

  task automatic t_cmp_signed();
    for (int c = 0; c < 6; c++) begin
      run("R1", 6'(c), 32'hFFFF_FFF0, 0, 32'd5, 0, 0);
      run("R1", 6'(c), 32'd7, 0, 32'd7, 0, 1);
      run("R1", 6'(c), 32'h7FFF_FFFF, 0, 32'h8000_0000, 0, 0);
    end
  endtask

  task automatic t_cmp_unsigned();
    for (int c = 0; c < 6; c++) begin
      run("R2", 6'(8 + c), 32'hFFFF_FFF0, 0, 32'd5, 0, 0);
      run("R2", 6'(8 + c), 32'd9, 0, 32'd9, 0, 0);
      run("R3", 6'(8 + c), 32'd1, 0, 32'd2, 0, 1);
    end
  endtask

  task automatic t_cmp_imm();
    for (int c = 0; c < 6; c++) begin
      run("R4", 6'(16 + c), 32'hFFFF_FFFF, 0, 32'd0, 16'hFFFF, 0);
      run("R4", 6'(16 + c), 32'd3, 0, 32'd3, 16'h8000, 0);
      run("R4", 6'(24 + c), 32'hFFFF_FFFF, 0, 32'd0, 16'hFFFF, 0);
      run("R4", 6'(24 + c), 32'd100, 0, 32'd0, 16'h0064, 1);
    end
  endtask

  task automatic t_movi();
    run("R5", 6'd6, 32'hDEAD_BEEF, 0, 0, 16'h8001, 0);
    run("R5", 6'd6, 32'h0, 0, 0, 16'h7ABC, 1);
  endtask

  task automatic t_cmovi();
    run("R6", 6'd7, 32'h1234_5678, 0, 0, 16'hFFFE, 1);
    run("R6", 6'd7, 32'h1234_5678, 0, 0, 16'hFFFE, 0);
  endtask

  task automatic t_addmul();
    run("R7", 6'd14, 32'd10, 0, 0, 16'hFFFF, 0);
    run("R7", 6'd14, 32'hFFFF_FFFF, 0, 0, 16'h0002, 0);
    run("R7", 6'd15, 32'd1000, 0, 0, 16'hFFFD, 0);
    run("R7", 6'd15, 32'h1000_0001, 0, 0, 16'h0010, 1);
  endtask

  task automatic t_bt32();
    run("R8", 6'd23, 32'h8000_0000, 0, 32'h0000_003F, 0, 0);
    run("R8", 6'd22, 32'h8000_0000, 0, 32'h0000_003F, 0, 1);
    run("R8", 6'd22, 32'h0000_0004, 0, 32'h0000_0022, 0, 0);
    run("R8", 6'd23, 32'h0000_0004, 0, 32'hFFFF_FFE2, 0, 0);
  endtask

  task automatic t_bt64();
    run("R9", 6'd31, 32'h0, 32'h0000_0001, 32'h0000_0020, 0, 0);
    run("R9", 6'd30, 32'h0, 32'h8000_0000, 32'h0000_00FF, 0, 1);
    run("R9", 6'd31, 32'h0000_0002, 32'h0, 32'h0000_0041, 0, 0);
  endtask

  task automatic t_illegal();
    run("R10", 6'd32, 32'h1, 0, 32'h1, 16'h1, 1);
    run("R10", 6'd63, 32'h5, 0, 32'h5, 16'h5, 0);
  endtask

  task automatic t_scc_pass();
    run("R11", 6'd14, 32'd1, 0, 0, 16'd1, 1);
    run("R11", 6'd6, 32'd1, 0, 0, 16'd1, 0);
  endtask

  task automatic t_stall();
    logic [36:0] held;
    run("R12", 6'd6, 0, 0, 0, 16'h4321, 0);
    held = model(6'd6, 0, 0, 0, 16'h4321, 0);
    out_ready = 1'b0;
    in_op = 6'd14; in_opa = 32'd50; in_imm = 16'd5; in_scc = 0; in_valid = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      compare("R12", held);
      nvec++;
      if (in_ready !== 1'b0) begin
        nerr++;
        $display("FAIL R12: got in_ready=%b expected 0", in_ready);
      end
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    compare("R12", model(6'd14, 32'd50, 0, 0, 16'd5, 0));
    @(posedge clk);
    @(negedge clk);
    nvec++;
    if (out_valid !== 1'b0) begin
      nerr++;
      $display("FAIL R11: got out_valid=%b expected 0", out_valid);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cmp_signed();
    t_cmp_unsigned();
    t_cmp_imm();
    t_movi();
    t_cmovi();
    t_addmul();
    t_bt32();
    t_bt64();
    t_illegal();
    t_scc_pass();
    t_stall();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      nerr++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end
endmodule